// File: doc/BRIEF.md
# SDRAM Burst and Auto-Precharge Tracker

This block sits on the controller side of a single-data-rate SDRAM command bus and shadows what the memory does with each registered command. It keeps track of which banks hold an open row. It follows the one READ or WRITE burst that can be in flight, and it works out the clock edge at which that burst finishes. When the finishing burst asked for an automatic precharge, the block marks that bank closed and pulses a per-bank flag. The controller can then schedule the next ACTIVE without having issued a PRECHARGE of its own.

The block samples one command per clock, together with the bank address and the A10 auto-precharge bit, and it also samples a burst-length code. Fixed lengths of 1, 2, 4 and 8 beats run down a counter. A full-page burst keeps running until something ends it, and it never precharges on its own. Each READ or WRITE brings its own auto-precharge choice. A burst that is cut short by a newer access, or by BURST TERMINATE, follows the rules listed below.

Top module: `sdram_burst_tracker`

## Requirements
- R1: After reset every bank reads idle, `burst_active` is low and `ap_start` is all zero.
- R2: Command codes on `cmd` are 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 BURST TERMINATE and 5 PRECHARGE. Every other code acts as NOP. ACTIVE sets the addressed bank open from the next cycle. PRECHARGE with `cmd_ap` low closes the addressed bank, and with `cmd_ap` high it closes every bank.
- R3: A READ or WRITE to an open bank starts a burst. For `bl_sel` from 0 to 3 the burst lasts 2^`bl_sel` beats, and `burst_active` is high for exactly that many cycles after the command edge.
- R4: When a fixed-length burst registered with `cmd_ap` high completes, its bank reads idle from the next cycle. On that same cycle `ap_start` shows a single one-cycle pulse on that bank's bit.
- R5: A fixed-length burst registered with `cmd_ap` low leaves its bank open and gives no `ap_start` pulse.
- R6: A `bl_sel` of 4 or more selects a full-page burst. That burst stays active until it is ended by a command, and it never produces an auto-precharge, even when `cmd_ap` is high.
- R7: BURST TERMINATE during a burst ends that burst at the edge on which the terminate is registered. If the burst carried an auto-precharge request, the precharge starts at that edge.
- R8: BURST TERMINATE with no burst in progress changes no output.
- R9: A READ or WRITE to an open bank during a burst replaces that burst. Only the auto-precharge setting of the new command is honoured. The replaced burst's request is dropped, and its bank stays open.
- R10: A READ or WRITE to an idle bank is ignored. It starts nothing, and a burst already in progress carries on unchanged.
- R11: A PRECHARGE that addresses the bank of the burst in progress, or that targets all banks, ends that burst with no `ap_start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Registered command code |
| cmd_bank | input | BANK_W | Bank address of the command |
| cmd_ap | input | 1 | A10: auto-precharge on READ/WRITE, all-banks on PRECHARGE |
| bl_sel | input | BL_SEL_W | Burst length code: 2^code beats for codes up to MAX_FIXED_LOG2, full page above |
| bank_open | output | NUM_BANKS | One bit per bank, high while a row is open |
| burst_active | output | 1 | High while a READ or WRITE burst is in progress |
| ap_start | output | NUM_BANKS | One-cycle pulse on the bank whose auto-precharge begins |

## Verification
Some properties are checked on every cycle. An auto-precharge pulse must be one-hot, must come right after a cycle with a burst in progress, and must coincide with its bank reading idle. No pulse may follow a full-page burst. A terminate with no burst, or an access to an idle bank, must leave the state alone. ACTIVE must open its bank and a single-bank PRECHARGE must close it. The exact burst durations for each length code need the bench's reference model running the scenarios. So do the replacement of a burst together with its precharge choice, the truncation timing and the all-bank precharge.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_BST = 3'd4,
      CMD_PRE = 3'd5
   } trk_cmd_e;

   function automatic logic is_access(input logic [2:0] c);
      return (c == CMD_RD) || (c == CMD_WR);
   endfunction

endpackage

// File: rtl/trk_cmd_decode.sv
module trk_cmd_decode
   import sdram_trk_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2
) (
   input  logic [2:0]           cmd,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic                 cmd_ap,
   input  logic [NUM_BANKS-1:0] bank_open,
   input  logic                 burst_active,
   input  logic [BANK_W-1:0]    burst_bank,
   output logic                 start,
   output logic                 bst_hit,
   output logic                 pre_kill,
   output logic [NUM_BANKS-1:0] act_mask,
   output logic [NUM_BANKS-1:0] pre_mask
);

   logic is_act, is_pre;

   assign is_act = (cmd == CMD_ACT);
   assign is_pre = (cmd == CMD_PRE);

   // an access only counts when its target row is open
   assign start    = is_access(cmd) && bank_open[cmd_bank];
   assign bst_hit  = (cmd == CMD_BST) && burst_active;
   assign pre_kill = is_pre && burst_active && (cmd_ap || (cmd_bank == burst_bank));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mask
      assign act_mask[b] = is_act && (cmd_bank == BANK_W'(b));
      assign pre_mask[b] = is_pre && (cmd_ap || (cmd_bank == BANK_W'(b)));
   end

endmodule

// File: rtl/trk_burst_unit.sv
module trk_burst_unit #(
   parameter int BANK_W         = 2,
   parameter int BL_SEL_W       = 3,
   parameter int MAX_FIXED_LOG2 = 3,
   localparam int CNT_W         = (MAX_FIXED_LOG2 < 1) ? 1 : MAX_FIXED_LOG2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [BANK_W-1:0]   start_bank,
   input  logic                start_ap,
   input  logic [BL_SEL_W-1:0] bl_sel,
   input  logic                bst_hit,
   input  logic                pre_kill,
   output logic                active,
   output logic [BANK_W-1:0]   bank,
   output logic                ap_fire
);

   logic             fixed_in;
   logic [CNT_W-1:0] len_m1;
   logic             fixed_q;
   logic             ap_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last_beat;

   assign fixed_in = (int'(bl_sel) <= MAX_FIXED_LOG2);
   assign len_m1   = CNT_W'((32'd1 << bl_sel) - 32'd1);

   assign last_beat = active && fixed_q && (cnt_q == '0);

   // truncation by terminate still counts as completion; precharge kill does not
   assign ap_fire = active && ap_q && !start && (bst_hit || (!pre_kill && last_beat));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         bank    <= '0;
         fixed_q <= 1'b0;
         ap_q    <= 1'b0;
         cnt_q   <= '0;
      end else if (start) begin
         active  <= 1'b1;
         bank    <= start_bank;
         fixed_q <= fixed_in;
         ap_q    <= start_ap && fixed_in;
         cnt_q   <= fixed_in ? len_m1 : '0;
      end else if (active) begin
         if (bst_hit || pre_kill || last_beat) begin
            active <= 1'b0;
            ap_q   <= 1'b0;
         end else if (fixed_q) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/trk_bank_state.sv
module trk_bank_state #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] act_mask,
   input  logic [NUM_BANKS-1:0] pre_mask,
   input  logic                 ap_fire,
   input  logic [BANK_W-1:0]    ap_bank,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic [NUM_BANKS-1:0] ap_start
);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic ap_here;
      assign ap_here = ap_fire && (ap_bank == BANK_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_open[b] <= 1'b0;
            ap_start[b]  <= 1'b0;
         end else begin
            ap_start[b] <= ap_here;
            if (act_mask[b])
               bank_open[b] <= 1'b1;
            else if (pre_mask[b] || ap_here)
               bank_open[b] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sdram_burst_tracker.sv
module sdram_burst_tracker
   import sdram_trk_pkg::*;
#(
   parameter int NUM_BANKS      = 4,
   parameter int BL_SEL_W       = 3,
   parameter int MAX_FIXED_LOG2 = 3,
   localparam int BANK_W        = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           cmd,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic                 cmd_ap,
   input  logic [BL_SEL_W-1:0]  bl_sel,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic                 burst_active,
   output logic [NUM_BANKS-1:0] ap_start
);

   initial begin
      if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS)
         $error("NUM_BANKS must be a power of two of at least 2");
      if (MAX_FIXED_LOG2 < 0 || MAX_FIXED_LOG2 >= (1 << BL_SEL_W) - 1)
         $error("BL_SEL_W leaves no code for full-page bursts");
   end

   logic                 start, bst_hit, pre_kill, ap_fire;
   logic [NUM_BANKS-1:0] act_mask, pre_mask;
   logic [BANK_W-1:0]    burst_bank;

   trk_cmd_decode #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W)
   ) u_dec (
      .cmd          (cmd),
      .cmd_bank     (cmd_bank),
      .cmd_ap       (cmd_ap),
      .bank_open    (bank_open),
      .burst_active (burst_active),
      .burst_bank   (burst_bank),
      .start        (start),
      .bst_hit      (bst_hit),
      .pre_kill     (pre_kill),
      .act_mask     (act_mask),
      .pre_mask     (pre_mask)
   );

   trk_burst_unit #(
      .BANK_W         (BANK_W),
      .BL_SEL_W       (BL_SEL_W),
      .MAX_FIXED_LOG2 (MAX_FIXED_LOG2)
   ) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_bank (cmd_bank),
      .start_ap   (cmd_ap),
      .bl_sel     (bl_sel),
      .bst_hit    (bst_hit),
      .pre_kill   (pre_kill),
      .active     (burst_active),
      .bank       (burst_bank),
      .ap_fire    (ap_fire)
   );

   trk_bank_state #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W)
   ) u_banks (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_mask  (act_mask),
      .pre_mask  (pre_mask),
      .ap_fire   (ap_fire),
      .ap_bank   (burst_bank),
      .bank_open (bank_open),
      .ap_start  (ap_start)
   );

endmodule

// File: rtl/sdram_burst_tracker_chk.sv
module sdram_burst_tracker_chk
   import sdram_trk_pkg::*;
#(
   parameter int NUM_BANKS      = 4,
   parameter int BL_SEL_W       = 3,
   parameter int MAX_FIXED_LOG2 = 3,
   localparam int BANK_W        = $clog2(NUM_BANKS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [2:0]           cmd,
   input logic [BANK_W-1:0]    cmd_bank,
   input logic                 cmd_ap,
   input logic [BL_SEL_W-1:0]  bl_sel,
   input logic [NUM_BANKS-1:0] bank_open,
   input logic                 burst_active,
   input logic [NUM_BANKS-1:0] ap_start
);

   // remembers whether the burst last accepted at the ports was full page
   logic fp_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fp_q <= 1'b0;
      else if (is_access(cmd) && bank_open[cmd_bank])
         fp_q <= (int'(bl_sel) > MAX_FIXED_LOG2);
   end

   AST_AP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ap_start)); // R4

   AST_AP_BANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|ap_start) |-> ((ap_start & bank_open) == '0)); // R4

   AST_AP_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (|ap_start) |-> $past(burst_active)); // R4

   AST_NO_AP_FULLPAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (|ap_start) |-> !$past(fp_q)); // R6

   AST_BST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_BST && !burst_active) |=> ($stable(bank_open) && !burst_active && ap_start == '0)); // R8

   AST_IDLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (is_access(cmd) && !bank_open[cmd_bank] && !burst_active) |=> !burst_active); // R10

   AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_ACT) |=> bank_open[$past(cmd_bank)]); // R2

   AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRE && !cmd_ap) |=> !bank_open[$past(cmd_bank)]); // R2

endmodule

bind sdram_burst_tracker sdram_burst_tracker_chk #(
   .NUM_BANKS      (NUM_BANKS),
   .BL_SEL_W       (BL_SEL_W),
   .MAX_FIXED_LOG2 (MAX_FIXED_LOG2)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd          (cmd),
   .cmd_bank     (cmd_bank),
   .cmd_ap       (cmd_ap),
   .bl_sel       (bl_sel),
   .bank_open    (bank_open),
   .burst_active (burst_active),
   .ap_start     (ap_start)
);

// File: tb/sdram_burst_tracker_test.sv
module sdram_burst_tracker_test;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    cmd = 3'd0;
   logic [1:0]    cmd_bank = '0;
   logic          cmd_ap = 1'b0;
   logic [2:0]    bl_sel = '0;
   logic [NB-1:0] bank_open;
   logic          burst_active;
   logic [NB-1:0] ap_start;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   // behavioural reference state
   logic [NB-1:0] m_open = '0;
   logic [NB-1:0] m_aps  = '0;
   bit            m_act  = 1'b0;
   int            m_left = 0;
   int            m_bank = 0;
   bit            m_fp   = 1'b0;
   bit            m_ap   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_burst_tracker uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd          (cmd),
      .cmd_bank     (cmd_bank),
      .cmd_ap       (cmd_ap),
      .bl_sel       (bl_sel),
      .bank_open    (bank_open),
      .burst_active (burst_active),
      .ap_start     (ap_start)
   );

   task automatic compare(input string tag);
      vectors++;
      if (bank_open !== m_open || burst_active !== m_act || ap_start !== m_aps) begin
         errors++;
         $display("FAIL %s: got open=%b active=%b ap=%b, expected open=%b active=%b ap=%b",
                  tag, bank_open, burst_active, ap_start, m_open, m_act, m_aps);
      end
   endtask

   task automatic model_step(input int c, input int b, input bit a);
      bit fire = 1'b0;
      int fbank = m_bank;
      bit go = (c == 2 || c == 3) && m_open[b];
      if (go) begin
         m_act  = 1'b1;
         m_bank = b;
         m_fp   = (bl_sel >= 4);
         m_left = m_fp ? 0 : (1 << bl_sel);
         m_ap   = a && !m_fp;
      end else if (m_act) begin
         if (c == 4) begin
            fire  = m_ap;
            m_act = 1'b0;
         end else if (c == 5 && (a || b == m_bank)) begin
            m_act = 1'b0;
         end else if (!m_fp) begin
            m_left--;
            if (m_left == 0) begin
               m_act = 1'b0;
               fire  = m_ap;
            end
         end
      end
      m_aps = '0;
      if (fire) begin
         m_open[fbank] = 1'b0;
         m_aps[fbank]  = 1'b1;
      end
      if (c == 5) begin
         if (a) m_open = '0;
         else   m_open[b] = 1'b0;
      end
      if (c == 1) m_open[b] = 1'b1;
   endtask

   task automatic tick(input int c, input int b, input bit a, input string tag);
      cmd      = 3'(c);
      cmd_bank = 2'(b);
      cmd_ap   = a;
      @(posedge clk);
      model_step(c, b, a);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) tick(0, 0, 1'b0, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got no finish, expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      bl_sel = 3'd2;                             // 4 beats
      tick(1, 0, 1'b0, "R2"); tick(1, 1, 1'b0, "R2");
      tick(2, 0, 1'b0, "R3"); idle(5, "R5");

      bl_sel = 3'd3;                             // 8 beats, auto-precharge
      tick(3, 1, 1'b1, "R3"); idle(9, "R4");
      tick(1, 1, 1'b0, "R2");
      bl_sel = 3'd0;                             // single beat
      tick(2, 1, 1'b1, "R4"); idle(2, "R4");
      tick(1, 1, 1'b0, "R2");
      bl_sel = 3'd1;                             // 2 beats
      tick(3, 0, 1'b1, "R4"); idle(3, "R4");
      tick(1, 0, 1'b0, "R2");

      bl_sel = 3'd7;                             // full page with A10 high
      tick(2, 0, 1'b1, "R6"); idle(20, "R6");
      tick(4, 0, 1'b0, "R7"); idle(2, "R6");

      tick(4, 2, 1'b0, "R8"); idle(1, "R8");
      tick(2, 2, 1'b0, "R10"); idle(2, "R10");

      bl_sel = 3'd3;
      tick(2, 0, 1'b1, "R9"); idle(2, "R9");
      tick(2, 1, 1'b0, "R9"); idle(10, "R9");
      tick(2, 1, 1'b0, "R9"); idle(1, "R9");
      tick(3, 0, 1'b1, "R9"); idle(10, "R9");
      tick(1, 0, 1'b0, "R2");

      tick(2, 0, 1'b1, "R7"); idle(2, "R7");
      tick(4, 0, 1'b0, "R7"); idle(2, "R7");
      tick(1, 0, 1'b0, "R2");

      tick(2, 0, 1'b1, "R10"); idle(1, "R10");
      tick(2, 3, 1'b0, "R10"); idle(8, "R10");
      tick(1, 0, 1'b0, "R2");

      tick(2, 0, 1'b1, "R11"); idle(1, "R11");
      tick(5, 0, 1'b0, "R11"); idle(8, "R11");

      tick(1, 0, 1'b0, "R2"); tick(1, 2, 1'b0, "R2"); tick(1, 3, 1'b0, "R2");
      bl_sel = 3'd6;
      tick(2, 2, 1'b0, "R6"); idle(3, "R6");
      tick(5, 1, 1'b1, "R11"); idle(2, "R2");
      tick(7, 0, 1'b0, "R2"); idle(1, "R2");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule